// File: doc/BRIEF.md
# Interrupt Pending and Fault Controller

This block gathers interrupt requests from several sources into a fifteen-bit pending register. The sources are external level inputs, timer wrap pulses, a fixed-point overflow flag and software writes. A mask register and a global enable gate the pending bits. From the bits that remain, the block presents the highest-priority one to the processor core as a request line and a bit index.

Four machine-error inputs feed sticky fault latches. The OR of those latches drives a single machine-error pending bit. While an error source is still active, a software clear of a fault bit or of the machine-error pending bit is undone on the following cycle.

The seven user request lines and the power-fail line are level sensitive. They pass through a one-cycle sample stage before entering the pending register, and they enter only on a latch strobe. A hold input, raised while the core fetches a call instruction, stops that transfer. Acknowledging a request clears its pending bit and drops the global enable. Software must set the enable again to allow a nested interrupt.

All pins are plain control and status signals; no interface carries a data stream, so there is no valid/ready back-pressure.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After reset the pending, mask and fault registers are zero, the enable is clear, and `irq_req_o` is low.
- R2: The pending bits are laid out as follows, with bit 0 the highest priority:
  - bit 0: power fail
  - bit 1: machine error
  - bits 2..8: user lines 0..6
  - bit 9: timer A
  - bit 10: timer B
  - bit 11: overflow
  - bits 12..14: software 1..3

  A high user or power-fail input is registered into a sample stage at a clock edge. The sampled value sets its pending bit at a later edge on which `latch_stb_i` is high and `hold_i` is low.
- R3: An input first sampled at the same edge as a strobe is not taken on that strobe. It waits for the next strobe.
- R4: While `hold_i` is high, no user or power-fail pending bit becomes set. Sampling continues, and the waiting value is taken on the first strobe after the hold is released.
- R5: Each machine-error input sets its own fault bit on the next edge and the bit stays set. The fault register (select 2) supports three operations:
  - a write loads `reg_wdata_i[3:0]`;
  - a clear empties the register;
  - during either operation, error inputs are ignored for that cycle, so a still-active source sets its bit again one cycle later.
- R6: Pending bit 1 is set on the edge after any fault bit is set. A clear of bit 1 takes effect for one cycle and is set again on the next edge if a fault bit remains.
- R7: A one-cycle pulse on `tim_a_wrap_i` sets pending bit 9. A one-cycle pulse on `tim_b_wrap_i` sets pending bit 10.
- R8: A write to the pending register (select 0) ORs `reg_wdata_i[14:12]` into bits 12..14. Such a write never clears a bit and leaves bits 0..11 unchanged.
- R9: A rising edge of `ovf_flag_i` sets bit 11 only while the enable is set and mask bit 11 is clear. In any other case the edge is ignored.
- R10: `irq_req_o` is high exactly when the enable is set and some pending bit has a clear mask bit. `irq_idx_o` is the lowest-numbered such bit.
- R11: `ack_i` while `irq_req_o` is high clears the pending bit named by `irq_idx_o` and clears the enable. This takes priority over a control write in the same cycle. `ack_i` has no effect while `irq_req_o` is low.
- R12: Register select codes are 0 = pending, 1 = mask, 2 = fault and 3 = control (enable in bit 0). The register operations are:
  - A clear on pending or mask clears the bits that are one in `reg_wdata_i`. A clear on pending beats any set in the same cycle.
  - A write to mask loads it.
  - A write to control loads the enable, and a clear on control drops it.
  - `reg_rdata_o` is a combinational view of the selected register, with unused bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| usr_irq_i | input | 7 | Level user request lines |
| pfail_i | input | 1 | Level power-fail line |
| merr_i | input | 4 | Machine-error inputs |
| tim_a_wrap_i | input | 1 | Timer A wrap pulse |
| tim_b_wrap_i | input | 1 | Timer B wrap pulse |
| ovf_flag_i | input | 1 | Fixed-point overflow flag |
| latch_stb_i | input | 1 | Strobe that moves samples into pending |
| hold_i | input | 1 | Suspends latching during call fetch |
| ack_i | input | 1 | Interrupt acknowledge |
| reg_sel_i | input | 2 | Register select |
| reg_wr_i | input | 1 | Register write |
| reg_clr_i | input | 1 | Register clear |
| reg_wdata_i | input | 16 | Write data or clear mask |
| reg_rdata_o | output | 16 | Selected register contents |
| irq_req_o | output | 1 | Interrupt request to core |
| irq_idx_o | output | 4 | Index of the granted pending bit |

## Verification
The assertions assume the following about the inputs:
- `reg_wr_i` and `reg_clr_i` are never both high.
- Each timer input is a single-cycle pulse.
- `ack_i` is meaningful only while a request is shown.

The bench raises write and clear on separate cycles. It drives timer pulses for one cycle only, and it issues acknowledges both with and without a pending request to check that the stray ones are ignored. The strobe has a fixed period of four cycles. Input changes are placed both just before and exactly on strobe edges, to exercise the late-sample case.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int N_USR  = 7;
  localparam int N_ERR  = 4;
  localparam int N_SW   = 3;
  localparam int NPEND  = 2 + N_USR + 2 + 1 + N_SW;
  localparam int IDXW   = $clog2(NPEND);
  localparam int DW     = 16;

  localparam int B_PFAIL = 0;
  localparam int B_MERR  = 1;
  localparam int B_USR0  = 2;
  localparam int B_TIMA  = B_USR0 + N_USR;
  localparam int B_TIMB  = B_TIMA + 1;
  localparam int B_OVF   = B_TIMB + 1;
  localparam int B_SW0   = B_OVF + 1;

  typedef enum logic [1:0] {
    SEL_PEND  = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_FAULT = 2'd2,
    SEL_CTRL  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_sampler.sv
module irq_sampler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic         stb_i,
  input  logic         hold_i,
  output logic [W-1:0] set_o
);
  logic [W-1:0] samp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) samp_q <= '0;
    else        samp_q <= lvl_i;
  end

  assign set_o = (stb_i && !hold_i) ? samp_q : '0;
endmodule

// File: rtl/irq_fault_reg.sv
module irq_fault_reg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] err_i,
  input  logic         wr_i,
  input  logic         clr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] fault_o,
  output logic         any_o
);
  logic [N-1:0] fault_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     fault_q <= '0;
    else if (wr_i)  fault_q <= wdata_i;
    else if (clr_i) fault_q <= '0;
    else            fault_q <= fault_q | err_i;
  end

  assign fault_o = fault_q;
  assign any_o   = |fault_q;

  // R5
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|err_i) && !wr_i && !clr_i) |=> ((fault_q & $past(err_i)) == $past(err_i)));

  // R5
  clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !wr_i) |=> (fault_q == '0));
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N  = 15,
  parameter int IW = 4
) (
  input  logic [N-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o = |vec_i;
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_USR-1:0] usr_irq_i,
  input  logic             pfail_i,
  input  logic [N_ERR-1:0] merr_i,
  input  logic             tim_a_wrap_i,
  input  logic             tim_b_wrap_i,
  input  logic             ovf_flag_i,
  input  logic             latch_stb_i,
  input  logic             hold_i,
  input  logic             ack_i,
  input  logic [1:0]       reg_sel_i,
  input  logic             reg_wr_i,
  input  logic             reg_clr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             irq_req_o,
  output logic [IDXW-1:0]  irq_idx_o
);
  localparam logic [NPEND-1:0] EXT_BITS =
    NPEND'(((1 << N_USR) - 1) << B_USR0) | NPEND'(1 << B_PFAIL);

  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_sel_i);

  logic [NPEND-1:0] pend_q, mask_q, set_v, clr_v, live_v;
  logic             en_q, en_d, ovf_q, ack_hit, any_live;
  logic [N_ERR-1:0] fault_v;
  logic             fault_any;
  logic [N_USR:0]   ext_set;

  irq_sampler #(.W(N_USR + 1)) u_samp (
    .clk(clk), .rst_n(rst_n), .lvl_i({usr_irq_i, pfail_i}),
    .stb_i(latch_stb_i), .hold_i(hold_i), .set_o(ext_set)
  );

  irq_fault_reg #(.N(N_ERR)) u_fault (
    .clk(clk), .rst_n(rst_n), .err_i(merr_i),
    .wr_i(reg_wr_i && sel == SEL_FAULT),
    .clr_i(reg_clr_i && sel == SEL_FAULT),
    .wdata_i(reg_wdata_i[N_ERR-1:0]),
    .fault_o(fault_v), .any_o(fault_any)
  );

  assign live_v = en_q ? (pend_q & ~mask_q) : '0;

  irq_prio #(.N(NPEND), .IW(IDXW)) u_prio (
    .vec_i(live_v), .any_o(any_live), .idx_o(irq_idx_o)
  );

  assign irq_req_o = any_live;
  assign ack_hit   = ack_i && irq_req_o;

  always_comb begin
    set_v                 = '0;
    set_v[B_PFAIL]        = ext_set[0];
    set_v[B_USR0 +: N_USR] = ext_set[N_USR:1];
    set_v[B_MERR]         = fault_any;
    set_v[B_TIMA]         = tim_a_wrap_i;
    set_v[B_TIMB]         = tim_b_wrap_i;
    set_v[B_OVF]          = ovf_flag_i && !ovf_q && en_q && !mask_q[B_OVF];
    if (reg_wr_i && sel == SEL_PEND)
      set_v[B_SW0 +: N_SW] = reg_wdata_i[B_SW0 +: N_SW];
  end

  always_comb begin
    clr_v = '0;
    if (ack_hit) clr_v[irq_idx_o] = 1'b1;
    if (reg_clr_i && sel == SEL_PEND) clr_v = clr_v | reg_wdata_i[NPEND-1:0];
  end

  always_comb begin
    en_d = en_q;
    if (reg_wr_i && sel == SEL_CTRL)       en_d = reg_wdata_i[0];
    else if (reg_clr_i && sel == SEL_CTRL) en_d = 1'b0;
    if (ack_hit) en_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
      en_q   <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q | set_v) & ~clr_v;
      en_q   <= en_d;
      ovf_q  <= ovf_flag_i;
      if (reg_wr_i && sel == SEL_MASK)       mask_q <= reg_wdata_i[NPEND-1:0];
      else if (reg_clr_i && sel == SEL_MASK) mask_q <= mask_q & ~reg_wdata_i[NPEND-1:0];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (sel)
      SEL_PEND:  reg_rdata_o[NPEND-1:0] = pend_q;
      SEL_MASK:  reg_rdata_o[NPEND-1:0] = mask_q;
      SEL_FAULT: reg_rdata_o[N_ERR-1:0] = fault_v;
      SEL_CTRL:  reg_rdata_o[0]         = en_q;
    endcase
  end

  // R10
  req_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> (en_q && pend_q[irq_idx_o] && !mask_q[irq_idx_o]));

  // R11
  ack_drop_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hit |=> !en_q);

  // R4
  hold_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (((pend_q & ~$past(pend_q)) & EXT_BITS) == '0));

  // R7
  tim_a_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tim_a_wrap_i && !clr_v[B_TIMA]) |=> pend_q[B_TIMA]);

  // R6
  merr_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_any && !clr_v[B_MERR]) |=> pend_q[B_MERR]);
endmodule

// File: tb/tb_irq_pend_ctrl.sv
module tb_irq_pend_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [6:0]  usr = '0;
  logic        pf = 0, ta = 0, tb = 0, ov = 0, stb = 0, hold = 0, ack = 0;
  logic [3:0]  me = '0;
  logic [1:0]  sel = '0;
  logic        wr = 0, clr = 0;
  logic [15:0] wd = '0, rdata;
  logic        req;
  logic [3:0]  idx;

  irq_pend_ctrl dut (
    .clk(clk), .rst_n(rst_n), .usr_irq_i(usr), .pfail_i(pf), .merr_i(me),
    .tim_a_wrap_i(ta), .tim_b_wrap_i(tb), .ovf_flag_i(ov), .latch_stb_i(stb),
    .hold_i(hold), .ack_i(ack), .reg_sel_i(sel), .reg_wr_i(wr), .reg_clr_i(clr),
    .reg_wdata_i(wd), .reg_rdata_o(rdata), .irq_req_o(req), .irq_idx_o(idx)
  );

  always #2.5 clk = ~clk;

  // behavioural reference state
  bit [14:0] m_pend, m_mask, m_s, m_c;
  bit [3:0]  m_fault;
  bit [7:0]  m_samp;
  bit        m_en, m_ovp, m_rq;
  int        m_ix;
  int        n_chk = 0, n_bad = 0, cyc = 0;
  string     tag = "R1";

  function automatic void pick(output bit rq, output int ix);
    rq = 0; ix = 0;
    if (m_en)
      for (int k = 14; k >= 0; k--)
        if (m_pend[k] && !m_mask[k]) begin rq = 1; ix = k; end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = '0; m_mask = '0; m_fault = '0; m_en = 0; m_samp = '0; m_ovp = 0;
    end else begin
      pick(m_rq, m_ix);
      m_s = '0; m_c = '0;
      if (stb && !hold) begin
        m_s[0] = m_samp[0];
        for (int k = 0; k < 7; k++) m_s[2+k] = m_samp[1+k];
      end
      m_s[1]  = (m_fault != 0);
      m_s[9]  = ta;
      m_s[10] = tb;
      m_s[11] = ov && !m_ovp && m_en && !m_mask[11];
      if (sel == 0 && wr) m_s[14:12] = wd[14:12];
      if (ack && m_rq) m_c[m_ix] = 1;
      if (sel == 0 && clr) m_c = m_c | wd[14:0];
      m_pend = (m_pend | m_s) & ~m_c;
      if (sel == 2 && wr) m_fault = wd[3:0];
      else if (sel == 2 && clr) m_fault = '0;
      else m_fault = m_fault | me;
      if (sel == 1 && wr) m_mask = wd[14:0];
      else if (sel == 1 && clr) m_mask = m_mask & ~wd[14:0];
      if (sel == 3 && wr) m_en = wd[0];
      else if (sel == 3 && clr) m_en = 0;
      if (ack && m_rq) m_en = 0;
      m_samp = {usr, pf};
      m_ovp = ov;
    end
  end

  task automatic check(string t, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h (cycle %0d)", t, what, got, exp, cyc);
    end
  endtask

  function automatic bit [15:0] m_read();
    case (sel)
      2'd0: return {1'b0, m_pend};
      2'd1: return {1'b0, m_mask};
      2'd2: return {12'b0, m_fault};
      default: return {15'b0, m_en};
    endcase
  endfunction

  // compare on every cycle, then release one-cycle pulses and drive the strobe
  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      bit rq; int ix;
      @(negedge clk);
      cyc++;
      pick(rq, ix);
      check(tag, "irq_req_o", req, rq);
      if (rq) check(tag, "irq_idx_o", idx, ix);
      check(tag, "reg_rdata_o", rdata, m_read());
      wr = 0; clr = 0; ack = 0; ta = 0; tb = 0;
      stb = (cyc % 4 == 3);
    end
  endtask

  task automatic rwr(logic [1:0] s, logic [15:0] d);
    sel = s; wd = d; wr = 1; step();
  endtask
  task automatic rclr(logic [1:0] s, logic [15:0] d);
    sel = s; wd = d; clr = 1; step();
  endtask

  bit wd_expired = 0;
  initial begin
    #(5.0 * 150000);
    wd_expired = 1;
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        // R1: reset state seen directly at the ports
        sel = 0; #0.1; check("R1", "pending after reset", rdata, 0);
        check("R1", "request after reset", req, 0);
        rst_n = 1;
        step(2);
        tag = "R12"; rwr(3, 16'h0001); step();
        // R2: user line 3 and power fail
        tag = "R2"; sel = 0; usr[3] = 1; step(6); usr[3] = 0; pf = 1; step(6); pf = 0; step(2);
        rclr(0, 16'h7fff); step();
        // R3: raise exactly as the strobe is driven
        tag = "R3";
        while (!stb) step();
        usr[6] = 1; step(); usr[6] = 0; step(6);
        rclr(0, 16'h7fff);
        // R4: hold across strobes
        tag = "R4"; hold = 1; usr[1] = 1; step(9); hold = 0; step(5); usr[1] = 0;
        rclr(0, 16'h7fff);
        // R5 / R6: fault latch set, clear while asserted, write
        tag = "R5"; sel = 2; me = 4'b0101; step(2); rclr(2, 0); step(2);
        me = 0; rclr(2, 0); step(); rwr(2, 16'h000a); step(); rclr(2, 0); step();
        tag = "R6"; sel = 0; me = 4'b1000; step(2); rclr(0, 16'h0002); step(2);
        me = 0; rclr(2, 0); rclr(0, 16'h0002); step(2);
        // R7: timer pulses
        tag = "R7"; ta = 1; step(); tb = 1; step(2); rclr(0, 16'h0600);
        // R8: software bits
        tag = "R8"; rwr(0, 16'h5000); step(); rwr(0, 16'h2fff); rwr(0, 16'h0000); step();
        rclr(0, 16'h7000);
        // R9: overflow edge with enable/mask variants
        tag = "R9"; ov = 1; step(2); ov = 0; step();
        rwr(1, 16'h0800); ov = 1; step(2); ov = 0; rclr(1, 16'hffff);
        rclr(3, 0); ov = 1; step(2); ov = 0; rwr(3, 16'h0001); step();
        rclr(0, 16'h7fff);
        // R10 / R11: priority, acknowledge, nested re-enable
        tag = "R10"; rwr(0, 16'h7000); step(); rwr(1, 16'h1000); step();
        tag = "R11"; ack = 1; step(2); ack = 1; step(); rwr(3, 16'h0001);
        ack = 1; sel = 3; wd = 1; wr = 1; step(); step(); rwr(3, 16'h0001);
        // randomised mix
        tag = "R10";
        for (int r = 0; r < 1500; r++) begin
          usr = $urandom; pf = ($urandom % 8 == 0); me = (($urandom % 16) == 0) ? 4'($urandom) : 4'h0;
          ta = ($urandom % 10 == 0); tb = ($urandom % 10 == 0); ov = $urandom;
          hold = ($urandom % 5 == 0); ack = ($urandom % 6 == 0);
          sel = $urandom; wd = $urandom;
          case ($urandom % 6) 0: wr = 1; 1: clr = 1; default: ; endcase
          step();
        end
      end
      begin
        wait (wd_expired);
      end
    join_any
    if (wd_expired) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule